// File: doc/BRIEF.md
# Iterative Multiply-Accumulate/Subtract Unit

This block computes `acc ± a * b` for a 64-bit integer pipeline. The accumulator is the present value of the destination register, and the two multiplicands come from two further read ports. The multiply is done by a shift-and-add engine that retires `STEP_BITS` multiplier bits per clock. Every legal operation therefore takes the same number of cycles. All arithmetic wraps modulo 2^XLEN, with no saturation and no overflow reporting.

Three result widths are offered:

- **Full width** keeps the low XLEN bits of the sum or difference.
- **Word form** keeps the low 32 bits and sign-extends them. It is legal only while the core runs in 64-bit mode.
- **Halfword form** sign-extends the low 16 bits of each multiplicand before multiplying. It then sign-extends bit 31 of the sum or difference into the full result.

An operation is launched with a one-cycle `start` while the unit is idle. `done` pulses once when the result is ready. An opcode that is illegal in the current mode is rejected in a single cycle: `done` and `illegal` pulse together and `result` is left untouched.

Top module: `mac_unit`

## Requirements
- R1: Opcode 3'b000 (bits [2:1] = 00 select full width, bit 0 = 0 selects add) produces `result = accIn + srcA * srcB`, low XLEN bits.
- R2: Opcode 3'b001 (full width, bit 0 = 1 selects subtract) produces `result = accIn - srcA * srcB`, low XLEN bits.
- R3: Opcodes 3'b100 (add) and 3'b101 (subtract) are the halfword forms, and they are legal in either mode. Each multiplicand is replaced by the sign extension of its bits [15:0]. The product is added to or subtracted from `accIn`. The result is bits [31:0] of that sum, sign-extended to XLEN.
- R4: Opcodes 3'b010 (add) and 3'b011 (subtract) are the word forms and are legal only when `wideMode` is 1. They produce `accIn ± srcA * srcB` with bits [31:0] sign-extended to XLEN.
- R5: The following starts are illegal: opcodes 3'b110 and 3'b111 in any mode, and a word opcode while `wideMode` is 0. An illegal start raises `done` and `illegal` together in the next cycle, for one cycle. `busy` stays low and `result` keeps its previous value.
- R6: A legal start sampled at clock edge E raises `busy` from E until edge E+XLEN/STEP_BITS. At that last edge `busy` falls and `done` is high for exactly one cycle, with `illegal` low and the new `result`. Outside that cycle `done` is low.
- R7: `start` is ignored while `busy` is high, whatever the opcode. It causes neither an extra `done` nor a change to the pending result.
- R8: Results wrap modulo the result width. Products and sums that overflow are truncated and never saturated.
- R9: After reset, `busy`, `done` and `illegal` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled only while idle |
| opcode | input | 3 | Bits [2:1] select the width (00 full, 01 word, 10 halfword, 11 illegal); bit 0 selects subtract |
| wideMode | input | 1 | 1 while the core runs in 64-bit mode |
| accIn | input | XLEN | Current destination value (accumulator) |
| srcA | input | XLEN | First multiplicand |
| srcB | input | XLEN | Second multiplicand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Qualifies `done`: the operation was rejected and no result was written |
| result | output | XLEN | Latest computed result |

## Verification
The bench builds the unit with its defaults, XLEN = 64 and STEP_BITS = 2. That gives a 32-cycle latency, so the bench can exercise several behaviours:

- a start pulse arriving mid-run that must be ignored;
- back-to-back launches issued in the cycle `done` is seen;
- full 64-bit wrap cases, where operands near the top of the range overflow both the product and the accumulate.

A behavioural model predicts `busy`, `done`, `illegal` and `result` every cycle. It uses the native multiply rather than a shift-add chain.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    W_FULL = 2'b00,
    W_WORD = 2'b01,
    W_HALF = 2'b10,
    W_BAD  = 2'b11
  } width_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } mac_strobe_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  width_e      widthSel,
  input  logic        wideMode,
  output mac_strobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        illegal
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic          runR;
  logic [CW-1:0] cntR;
  logic          doneR;
  logic          illR;
  logic          legal;

  assign legal = (widthSel != W_BAD) && !((widthSel == W_WORD) && !wideMode);

  always_comb begin
    strobe.load   = !runR && start && legal;
    strobe.step   = runR;
    strobe.finish = runR && (cntR == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runR  <= 1'b0;
      cntR  <= '0;
      doneR <= 1'b0;
      illR  <= 1'b0;
    end else begin
      doneR <= 1'b0;
      illR  <= 1'b0;
      if (!runR) begin
        if (start) begin
          if (legal) begin
            runR <= 1'b1;
            cntR <= '0;
          end else begin
            doneR <= 1'b1;
            illR  <= 1'b1;
          end
        end
      end else begin
        cntR <= cntR + 1'b1;
        if (cntR == LAST) begin
          runR  <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign busy    = runR;
  assign done    = doneR;
  assign illegal = illR;

  AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (done && !busy)); // R5
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && !illegal)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (cntR != LAST)) |=> (busy && !done)); // R7

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int STEP_BITS = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  mac_strobe_t     strobe,
  input  width_e          widthSel,
  input  logic            subSel,
  input  logic [XLEN-1:0] accIn,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic [XLEN-1:0] result
);
  localparam int HW = 16;
  localparam int WW = 32;

  logic [XLEN-1:0] accR, mcandR, mplierR, prodR, resultR;
  logic [XLEN-1:0] partial, prodNext, sumVal, finalVal;
  logic [XLEN-1:0] opA, opB;
  width_e          widthR;
  logic            subR;

  function automatic logic [XLEN-1:0] narrowOp(input logic [XLEN-1:0] v, input width_e w);
    if (w == W_HALF) return {{(XLEN-HW){v[HW-1]}}, v[HW-1:0]};
    return v;
  endfunction

  assign opA = narrowOp(srcA, widthSel);
  assign opB = narrowOp(srcB, widthSel);

  always_comb begin
    partial = '0;
    for (int b = 0; b < STEP_BITS; b++) begin
      if (mplierR[b]) partial = partial + (mcandR << b);
    end
    prodNext = prodR + partial;
    sumVal   = subR ? (accR - prodNext) : (accR + prodNext);
    if (widthR == W_FULL) finalVal = sumVal;
    else                  finalVal = {{(XLEN-WW){sumVal[WW-1]}}, sumVal[WW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accR    <= '0;
      mcandR  <= '0;
      mplierR <= '0;
      prodR   <= '0;
      resultR <= '0;
      widthR  <= W_FULL;
      subR    <= 1'b0;
    end else begin
      if (strobe.load) begin
        accR    <= accIn;
        mcandR  <= opA;
        mplierR <= opB;
        prodR   <= '0;
        widthR  <= widthSel;
        subR    <= subSel;
      end else if (strobe.step) begin
        prodR   <= prodNext;
        mcandR  <= mcandR << STEP_BITS;
        mplierR <= mplierR >> STEP_BITS;
      end
      if (strobe.finish) resultR <= finalVal;
    end
  end

  assign result = resultR;

  AST_NARROW_SIGNEXT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.finish) && (widthR != W_FULL)) |->
      (resultR[XLEN-1:WW] == {(XLEN-WW){resultR[WW-1]}})); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(resultR)); // R5

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int STEP_BITS = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [2:0]      opcode,
  input  logic            wideMode,
  input  logic [XLEN-1:0] accIn,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic [XLEN-1:0] result
);
  localparam int STEPS = XLEN / STEP_BITS;

  mac_strobe_t strobe;
  width_e      widthSel;
  logic        subSel;

  assign widthSel = width_e'(opcode[2:1]);
  assign subSel   = opcode[0];

  mac_ctrl #(.STEPS(STEPS)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .widthSel(widthSel),
    .wideMode(wideMode), .strobe(strobe), .busy(busy), .done(done),
    .illegal(illegal)
  );

  mac_datapath #(.XLEN(XLEN), .STEP_BITS(STEP_BITS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .widthSel(widthSel),
    .subSel(subSel), .accIn(accIn), .srcA(srcA), .srcB(srcB),
    .result(result)
  );

endmodule

// File: tb/mac_unit_test.sv
module mac_unit_test;
  localparam int STEPS = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opcode = '0;
  logic        wideMode = 1'b1;
  logic [63:0] accIn = '0, srcA = '0, srcB = '0;
  logic        busy, done, illegal;
  logic [63:0] result;

  int nChk = 0, nFail = 0, cyc = 0;
  bit finished = 0;

  bit          mBusy = 0, expDone = 0, expIll = 0;
  int          mCnt = 0;
  logic [63:0] mPend = '0, expRes = '0;
  string       curTag = "R1", mTag = "R1", resTag = "R9";

  always #5 clk = ~clk;

  mac_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .wideMode(wideMode),
    .accIn(accIn), .srcA(srcA), .srcB(srcB), .busy(busy), .done(done),
    .illegal(illegal), .result(result)
  );

  function automatic logic [63:0] refCalc(input logic [2:0] op, input logic [63:0] acc,
                                          input logic [63:0] a, input logic [63:0] b);
    logic [63:0] x, y, p, s;
    x = a; y = b;
    if (op[2:1] == 2'b10) begin
      x = {{48{a[15]}}, a[15:0]};
      y = {{48{b[15]}}, b[15:0]};
    end
    p = x * y;
    s = op[0] ? acc - p : acc + p;
    if (op[2:1] != 2'b00) s = {{32{s[31]}}, s[31:0]};
    return s;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    expDone = 0;
    expIll  = 0;
    if (!rstN) begin
      mBusy = 0; mCnt = 0; expRes = '0; resTag = "R9";
    end else if (mBusy) begin
      mCnt++;
      if (mCnt == STEPS) begin
        mBusy = 0; expDone = 1; expRes = mPend; resTag = mTag;
      end
    end else if (start) begin
      if (opcode[2:1] != 2'b11 && !(opcode[2:1] == 2'b01 && !wideMode)) begin
        mBusy = 1; mCnt = 0; mPend = refCalc(opcode, accIn, srcA, srcB); mTag = curTag;
      end else begin
        expDone = 1; expIll = 1; resTag = "R5";
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R6 busy", {63'd0, busy}, {63'd0, mBusy});
      chk("R6 done", {63'd0, done}, {63'd0, expDone});
      chk("R5 illegal", {63'd0, illegal}, {63'd0, expIll});
      chk({resTag, " result"}, result, expRes);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  task automatic poke(input logic [2:0] op, input logic wm, input logic [63:0] acc,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    opcode = op; wideMode = wm; accIn = acc; srcA = a; srcB = b; curTag = tag;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    accIn = '0; srcA = '0; srcB = '0;
  endtask

  task automatic go(input logic [2:0] op, input logic wm, input logic [63:0] acc,
                    input logic [63:0] a, input logic [63:0] b, input string tag);
    while (mBusy) @(negedge clk);
    poke(op, wm, acc, a, b, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state (also checked each cycle by the compare block)
    chk("R9 busy", {63'd0, busy}, 64'd0);
    chk("R9 done", {63'd0, done}, 64'd0);
    chk("R9 result", result, 64'd0);

    go(3'b000, 1, 64'd1000, 64'd123456789, 64'd987654321, "R1");
    go(3'b001, 1, 64'd5, 64'h0000_0001_0000_0003, 64'd7, "R2");
    go(3'b010, 1, 64'h1234_5678_7FFF_FFF0, 64'd4, 64'd9, "R4");
    go(3'b011, 1, 64'd0, 64'd3, 64'd5, "R4");
    go(3'b100, 1, 64'd10, 64'hDEAD_BEEF_CAFE_8000, 64'h1111_2222_3333_FFFE, "R3");
    go(3'b101, 0, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_7FFF, 64'h0000_0000_0000_7FFF, "R3");
    go(3'b100, 0, 64'h0000_0000_7FFF_FFFF, 64'd1, 64'd1, "R3");
    go(3'b010, 0, 64'd1, 64'd2, 64'd3, "R5");
    go(3'b110, 1, 64'd1, 64'd2, 64'd3, "R5");
    go(3'b111, 0, 64'd1, 64'd2, 64'd3, "R5");
    go(3'b000, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, "R8");
    go(3'b001, 1, 64'd0, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    go(3'b000, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1_0000_0000, 64'h1_0000_0000, "R8");
    // R7: start pulses mid-run must be ignored
    go(3'b000, 1, 64'd42, 64'd6, 64'd7, "R7");
    repeat (3) @(negedge clk);
    poke(3'b111, 1, 64'd9, 64'd9, 64'd9, "R7");
    repeat (4) @(negedge clk);
    poke(3'b001, 1, 64'd9, 64'd9, 64'd9, "R7");
    go(3'b011, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R4");
    go(3'b001, 1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0F0F_0F0F_0F0F_0F0F, "R2");
    while (mBusy) @(negedge clk);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule